// File: doc/BRIEF.md
# 68000-Style Host Bus Cycle Engine

This block lets a fast 32-bit processor on an accelerator card run on the 16-bit bus of a slower host board. The host bus is the classic asynchronous 68000 bus. It is clocked at about 8 MHz, and the host logic terminates each cycle with DTACK in step with that clock. The engine runs on its own fast core clock. It samples the host clock, the host DTACK and the bus grant through two-stage synchronizers. It then steps every host cycle through eight half-clock phases, S0 to S7, and each phase changes on an edge of the host clock.

At startup the engine requests the host bus from the resident 68000 and holds the new processor in reset. It releases that reset only after the grant arrives. From then on, each processor access becomes one host cycle, or two host cycles for a 32-bit access, and ends with a single-cycle termination back to the processor. A full host clock of idle time always separates two host cycles. This keeps the host's synchronous logic from missing the start of a cycle when the faster processor issues accesses back to back.

Top module: `bce_bridge`

## Requirements
- R1: While reset is applied, `host_br_n` is 1. On the first core clock after reset is released, `host_br_n` goes to 0. At that point `cpu_rst_n` is 0, `host_own` is 0, `cpu_ack` is 0, and `host_as_n`, `host_uds_n` and `host_lds_n` are 1.
- R2: As long as `host_bg_n` stays 1, `cpu_rst_n` and `host_own` stay 0 and no host cycle starts. Three core clocks after `host_bg_n` goes to 0, `cpu_rst_n` and `host_own` are 1.
- R3: `host_rw` is 1 for a read and 0 for a write for the whole time `host_as_n` is 0. `host_addr` does not change while `host_as_n` is 0.
- R4: Size code 00 (long) produces two host cycles. The first uses word address {A[AW-1:2],0} and the second uses {A[AW-1:2],1}. For a read, the first half lands in `cpu_rdata[31:16]`. For a write, the first cycle carries `cpu_wdata[31:16]` and the second carries `cpu_wdata[15:0]`.
- R5: Size code 01 (byte) selects the lane from address bit 0. An even address asserts only `host_uds_n` (bits 15:8) and an odd address asserts only `host_lds_n` (bits 7:0). Size codes 10 (word) and 00 (long) assert both strobes, and the host address is A[AW-1:1]. A data strobe is only ever asserted while `host_as_n` is 0.
- R6: Write data on the host bus is `cpu_wdata[15:0]` for a word and {`cpu_wdata[7:0]`,`cpu_wdata[7:0]`} for a byte. Read data returns as {16'h0,D} for a word, and for a byte as {24'h0,D[15:8]} when the address is even or {24'h0,D[7:0]} when it is odd.
- R7: Between two host cycles, including the two halves of a long access, `host_as_n` stays 1 across at least three consecutive rising edges of `hclk`.
- R8: The address strobe and data strobes stay asserted until the host has driven `host_dtack_n` to 0. Wait states are added for as long as DTACK is late.
- R9: Each access produces exactly one `cpu_ack` pulse, one core clock wide. It comes after the last host cycle of that access has ended, and `cpu_rdata` is valid during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| hclk | input | 1 | Host system clock, asynchronous to clk |
| host_br_n | output | 1 | Bus request to the resident 68000 |
| host_bg_n | input | 1 | Bus grant from the resident 68000 |
| host_own | output | 1 | High once the host bus is owned; enables the host drivers |
| cpu_rst_n | output | 1 | Reset to the fast processor |
| cpu_req | input | 1 | Access request, held until cpu_ack |
| cpu_addr | input | AW | Byte address |
| cpu_we | input | 1 | 1 = write |
| cpu_size | input | 2 | 00 long, 01 byte, 10 word |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | Access termination pulse |
| host_addr | output | AW-1 | Host word address |
| host_as_n | output | 1 | Address strobe |
| host_uds_n | output | 1 | Upper data strobe |
| host_lds_n | output | 1 | Lower data strobe |
| host_rw | output | 1 | 1 = read, 0 = write |
| host_doe | output | 1 | Host data bus output enable |
| host_dout | output | 16 | Host write data |
| host_din | input | 16 | Host read data |
| host_dtack_n | input | 1 | Host cycle termination |

## Verification
If the phase sequencer is in the wrong state, a strobe shows up outside the address strobe, or a cycle starts before the idle host clock has passed. Either fault is visible on the host pins within one host clock. A wrong half flag or a wrong lane decode shows up as a wrong word address, strobe pair or data word on the very next access. An error in the termination logic shows up as a missing or doubled `cpu_ack` within a few host clocks of the final cycle. The sweep covers every size, direction and low address pair under several DTACK delays, so each of these faults surfaces on the access where it first occurs.

// File: rtl/bce_pkg.sv
package bce_pkg;

    localparam int CPU_DW  = 32;
    localparam int HOST_DW = 16;

    // transfer size encodings on the processor side
    localparam logic [1:0] SZ_LONG = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    // host cycle phases; each one lasts half a host clock
    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_S0   = 4'd1,
        ST_S1   = 4'd2,
        ST_S2   = 4'd3,
        ST_S3   = 4'd4,
        ST_S4   = 4'd5,
        ST_S5   = 4'd6,
        ST_S6   = 4'd7,
        ST_S7   = 4'd8
    } bus_st_e;

endpackage

// File: rtl/bce_sync.sv
module bce_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st1_d, st1_q, st2_d, st2_q;

    always_comb begin
        st1_d = din;
        st2_d = st1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st1_q <= RST_VAL;
            st2_q <= RST_VAL;
        end else begin
            st1_q <= st1_d;
            st2_q <= st2_d;
        end
    end

    assign dout = st2_q;
endmodule

// File: rtl/bce_edge.sv
module bce_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
        fall   = ~lvl & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/bce_lanes.sv
module bce_lanes
    import bce_pkg::*;
(
    input  logic [1:0]         size,
    input  logic               addr0,
    input  logic               half,
    input  logic [CPU_DW-1:0]  wdata,
    input  logic [HOST_DW-1:0] rd_hi,
    input  logic [HOST_DW-1:0] rd_lo,
    output logic               up_en,
    output logic               lo_en,
    output logic [HOST_DW-1:0] dout,
    output logic [CPU_DW-1:0]  asm_rdata
);
    localparam int BW = HOST_DW / 2;

    always_comb begin
        up_en = 1'b1;
        lo_en = 1'b1;
        if (size == SZ_BYTE) begin
            up_en = ~addr0;
            lo_en = addr0;
        end

        case (size)
            SZ_LONG: dout = half ? wdata[HOST_DW-1:0] : wdata[CPU_DW-1:HOST_DW];
            SZ_WORD: dout = wdata[HOST_DW-1:0];
            default: dout = {wdata[BW-1:0], wdata[BW-1:0]};
        endcase

        case (size)
            SZ_LONG: asm_rdata = {rd_hi, rd_lo};
            SZ_WORD: asm_rdata = {{(CPU_DW-HOST_DW){1'b0}}, rd_lo};
            default: asm_rdata = {{(CPU_DW-BW){1'b0}},
                                  addr0 ? rd_lo[BW-1:0] : rd_lo[HOST_DW-1:BW]};
        endcase
    end
endmodule

// File: rtl/bce_seq.sv
module bce_seq
    import bce_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hrise,
    input  logic               hfall,
    input  logic               bg_n_s,
    input  logic               dtack_n_s,
    input  logic               cpu_req,
    input  logic [AW-1:0]      cpu_addr,
    input  logic               cpu_we,
    input  logic [1:0]         cpu_size,
    input  logic [CPU_DW-1:0]  cpu_wdata,
    input  logic [HOST_DW-1:0] host_din,
    input  logic [CPU_DW-1:0]  asm_rdata,
    output logic               br_q,
    output logic               owned_q,
    output bus_st_e            st_q,
    output logic               half_q,
    output logic [AW-1:0]      addr_q,
    output logic               we_q,
    output logic [1:0]         size_q,
    output logic [CPU_DW-1:0]  wdata_q,
    output logic [HOST_DW-1:0] rd_hi_q,
    output logic [HOST_DW-1:0] rd_lo_q,
    output logic [CPU_DW-1:0]  rdata_q,
    output logic               ack_q
);
    typedef struct packed {
        logic               br;
        logic               owned;
        bus_st_e            st;
        logic               half;
        logic [AW-1:0]      addr;
        logic               we;
        logic [1:0]         size;
        logic [CPU_DW-1:0]  wdata;
        logic [HOST_DW-1:0] rd_hi;
        logic [HOST_DW-1:0] rd_lo;
        logic [CPU_DW-1:0]  rdata;
        logic               ack;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.ack = 1'b0;
        r_d.br  = 1'b1;

        if (!r_q.owned) begin
            // take the bus first, then let the processor out of reset
            if (r_q.br && !bg_n_s) r_d.owned = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (hrise) begin
                        if (r_q.half) begin
                            r_d.st = ST_S0;
                        end else if (cpu_req && !r_q.ack) begin
                            r_d.st    = ST_S0;
                            r_d.addr  = cpu_addr;
                            r_d.we    = cpu_we;
                            r_d.size  = cpu_size;
                            r_d.wdata = cpu_wdata;
                        end
                    end
                end
                ST_S0: if (hfall) r_d.st = ST_S1;
                ST_S1: if (hrise) r_d.st = ST_S2;
                ST_S2: if (hfall) r_d.st = ST_S3;
                ST_S3: if (hrise) r_d.st = ST_S4;
                ST_S4: if (hfall && !dtack_n_s) r_d.st = ST_S5;
                ST_S5: if (hrise) r_d.st = ST_S6;
                ST_S6: begin
                    if (hfall) begin
                        r_d.st = ST_S7;
                        if (r_q.size == SZ_LONG && !r_q.half) r_d.rd_hi = host_din;
                        else                                  r_d.rd_lo = host_din;
                    end
                end
                ST_S7: begin
                    if (hrise) begin
                        r_d.st = ST_IDLE;
                        if (r_q.size == SZ_LONG && !r_q.half) begin
                            r_d.half = 1'b1;
                        end else begin
                            r_d.half  = 1'b0;
                            r_d.ack   = 1'b1;
                            r_d.rdata = asm_rdata;
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign br_q    = r_q.br;
    assign owned_q = r_q.owned;
    assign st_q    = r_q.st;
    assign half_q  = r_q.half;
    assign addr_q  = r_q.addr;
    assign we_q    = r_q.we;
    assign size_q  = r_q.size;
    assign wdata_q = r_q.wdata;
    assign rd_hi_q = r_q.rd_hi;
    assign rd_lo_q = r_q.rd_lo;
    assign rdata_q = r_q.rdata;
    assign ack_q   = r_q.ack;
endmodule

// File: rtl/bce_bridge.sv
module bce_bridge
    import bce_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hclk,
    output logic               host_br_n,
    input  logic               host_bg_n,
    output logic               host_own,
    output logic               cpu_rst_n,
    input  logic               cpu_req,
    input  logic [AW-1:0]      cpu_addr,
    input  logic               cpu_we,
    input  logic [1:0]         cpu_size,
    input  logic [CPU_DW-1:0]  cpu_wdata,
    output logic [CPU_DW-1:0]  cpu_rdata,
    output logic               cpu_ack,
    output logic [AW-1:1]      host_addr,
    output logic               host_as_n,
    output logic               host_uds_n,
    output logic               host_lds_n,
    output logic               host_rw,
    output logic               host_doe,
    output logic [HOST_DW-1:0] host_dout,
    input  logic [HOST_DW-1:0] host_din,
    input  logic               host_dtack_n
);
    logic [2:0]         sync_out;
    logic               hclk_s, dtack_n_s, bg_n_s;
    logic               hclk_rise, hclk_fall;
    logic               br_q, owned_q, half_q, we_q, ack_q;
    bus_st_e            st_q;
    logic [AW-1:0]      addr_q;
    logic [1:0]         size_q;
    logic [CPU_DW-1:0]  wdata_q, rdata_q, asm_rdata;
    logic [HOST_DW-1:0] rd_hi_q, rd_lo_q, lane_dout;
    logic               up_en, lo_en;
    logic               as_act, ds_act, drive_act;

    bce_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({host_bg_n, host_dtack_n, hclk}),
        .dout (sync_out)
    );
    assign {bg_n_s, dtack_n_s, hclk_s} = sync_out;

    bce_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (hclk_s),
        .rise (hclk_rise),
        .fall (hclk_fall)
    );

    bce_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hrise    (hclk_rise),
        .hfall    (hclk_fall),
        .bg_n_s   (bg_n_s),
        .dtack_n_s(dtack_n_s),
        .cpu_req  (cpu_req),
        .cpu_addr (cpu_addr),
        .cpu_we   (cpu_we),
        .cpu_size (cpu_size),
        .cpu_wdata(cpu_wdata),
        .host_din (host_din),
        .asm_rdata(asm_rdata),
        .br_q     (br_q),
        .owned_q  (owned_q),
        .st_q     (st_q),
        .half_q   (half_q),
        .addr_q   (addr_q),
        .we_q     (we_q),
        .size_q   (size_q),
        .wdata_q  (wdata_q),
        .rd_hi_q  (rd_hi_q),
        .rd_lo_q  (rd_lo_q),
        .rdata_q  (rdata_q),
        .ack_q    (ack_q)
    );

    bce_lanes u_lanes (
        .size     (size_q),
        .addr0    (addr_q[0]),
        .half     (half_q),
        .wdata    (wdata_q),
        .rd_hi    (rd_hi_q),
        .rd_lo    (rd_lo_q),
        .up_en    (up_en),
        .lo_en    (lo_en),
        .dout     (lane_dout),
        .asm_rdata(asm_rdata)
    );

    always_comb begin
        as_act    = st_q inside {ST_S2, ST_S3, ST_S4, ST_S5, ST_S6};
        // write strobes wait until the data has settled on the bus
        ds_act    = we_q ? (st_q inside {ST_S4, ST_S5, ST_S6}) : as_act;
        drive_act = st_q inside {ST_S3, ST_S4, ST_S5, ST_S6, ST_S7};

        host_br_n  = ~br_q;
        host_own   = owned_q;
        cpu_rst_n  = owned_q;
        host_as_n  = ~as_act;
        host_uds_n = ~(ds_act & up_en);
        host_lds_n = ~(ds_act & lo_en);
        host_rw    = ~(we_q & (st_q != ST_IDLE));
        host_doe   = owned_q & we_q & drive_act;
        host_dout  = lane_dout;
        host_addr  = {addr_q[AW-1:2], (size_q == SZ_LONG) ? half_q : addr_q[1]};
        cpu_ack    = ack_q;
        cpu_rdata  = rdata_q;
    end
endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_as_n,
    input logic          host_uds_n,
    input logic          host_lds_n,
    input logic          host_rw,
    input logic [AW-1:1] host_addr,
    input logic          host_dtack_n,
    input logic          cpu_ack,
    input logic          cpu_rst_n,
    input logic          hrise
);
    logic       seen_d, seen_q;
    logic [2:0] gap_d, gap_q;

    always_comb begin
        seen_d = host_as_n ? 1'b0 : (seen_q | ~host_dtack_n);
        gap_d  = gap_q;
        if (!host_as_n)               gap_d = 3'd0;
        else if (hrise && gap_q != 3'd7) gap_d = gap_q + 3'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            gap_q  <= 3'd7;
        end else begin
            seen_q <= seen_d;
            gap_q  <= gap_d;
        end
    end

    assert_no_cycle_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rst_n |-> host_as_n);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_as_n && $past(!host_as_n)) |-> ($stable(host_addr) && $stable(host_rw)));

    assert_ds_inside_as_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_uds_n || !host_lds_n) |-> !host_as_n);

    assert_idle_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_as_n) |-> (gap_q >= 3'd3));

    assert_dtack_before_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_as_n) |-> seen_q);

    assert_ack_bus_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> host_as_n);

    assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);
endmodule

bind bce_bridge bce_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_as_n   (host_as_n),
    .host_uds_n  (host_uds_n),
    .host_lds_n  (host_lds_n),
    .host_rw     (host_rw),
    .host_addr   (host_addr),
    .host_dtack_n(host_dtack_n),
    .cpu_ack     (cpu_ack),
    .cpu_rst_n   (cpu_rst_n),
    .hrise       (hclk_rise)
);

// File: tb/tb_bce_bridge.sv
module tb_bce_bridge;
    localparam int AW = 24;

    logic        clk = 1'b0, rst_n = 1'b0, hclk = 1'b0;
    logic        host_br_n, host_bg_n, host_own, cpu_rst_n;
    logic        cpu_req, cpu_we, cpu_ack;
    logic [AW-1:0] cpu_addr;
    logic [1:0]  cpu_size;
    logic [31:0] cpu_wdata, cpu_rdata;
    logic [AW-1:1] host_addr;
    logic        host_as_n, host_uds_n, host_lds_n, host_rw, host_doe;
    logic [15:0] host_dout, host_din;
    logic        host_dtack_n;

    always #5 clk = ~clk;
    initial begin #2; forever #40 hclk = ~hclk; end

    bce_bridge #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .hclk(hclk),
        .host_br_n(host_br_n), .host_bg_n(host_bg_n), .host_own(host_own),
        .cpu_rst_n(cpu_rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .host_addr(host_addr),
        .host_as_n(host_as_n), .host_uds_n(host_uds_n), .host_lds_n(host_lds_n),
        .host_rw(host_rw), .host_doe(host_doe), .host_dout(host_dout),
        .host_din(host_din), .host_dtack_n(host_dtack_n)
    );

    int nvec = 0, nfail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rdfun(input logic [AW-2:0] wa);
        return {wa[7:0] ^ 8'h5A, wa[7:0] + 8'h33};
    endfunction

    // host bus model: records cycles, answers with DTACK after a chosen delay
    int          wait_sel = 0;
    int          nrec = 0, nack = 0;
    logic [AW-2:0] rec_addr [0:511];
    logic        rec_up [0:511], rec_lo [0:511], rec_rw [0:511];
    logic [15:0] rec_dout [0:511];
    logic        hclk_d = 1'b0, as_prev = 1'b1, dt_given = 1'b0;
    logic        cur_up, cur_lo, cur_rw;
    logic [AW-2:0] cur_addr;
    logic [15:0] cur_dout;
    int          wcnt = 0, gap_cnt = 7;

    always @(negedge clk) begin
        logic hr;
        hr = hclk && !hclk_d;
        hclk_d = hclk;
        if (cpu_ack) nack++;
        if (rst_n) begin
            if (!host_as_n) begin
                if (as_prev) begin
                    chk(gap_cnt >= 3, "R7 idle host clocks before cycle", gap_cnt, 3);
                    wcnt = 0; cur_up = 0; cur_lo = 0; cur_dout = 16'h0;
                    cur_addr = host_addr; cur_rw = host_rw; dt_given = 0;
                end else if (hr) wcnt++;
                if (!host_uds_n) cur_up = 1;
                if (!host_lds_n) cur_lo = 1;
                if (!host_rw && host_doe && (!host_uds_n || !host_lds_n)) cur_dout = host_dout;
                if (wcnt >= wait_sel) begin
                    host_dtack_n = 1'b0;
                    host_din = rdfun(cur_addr);
                    dt_given = 1;
                end
            end else begin
                if (!as_prev) begin
                    chk(dt_given, "R8 strobes held until DTACK", dt_given, 1);
                    if (nrec < 512) begin
                        rec_addr[nrec] = cur_addr; rec_up[nrec] = cur_up;
                        rec_lo[nrec] = cur_lo; rec_rw[nrec] = cur_rw;
                        rec_dout[nrec] = cur_dout;
                    end
                    nrec++;
                    host_dtack_n = 1'b1;
                    host_din = 16'h0;
                    gap_cnt = 0;
                end else if (hr && gap_cnt < 7) gap_cnt++;
            end
        end
        as_prev = host_as_n;
    end

    task automatic do_access(input logic [AW-1:0] a, input logic we, input logic [1:0] sz,
                             input logic [31:0] wd, input int wsel);
        int base_r, base_a, nexp;
        bit got;
        logic [31:0] rd, rexp;
        base_r = nrec; base_a = nack; wait_sel = wsel; got = 0; rd = '0;
        @(negedge clk);
        cpu_addr = a; cpu_we = we; cpu_size = sz; cpu_wdata = wd; cpu_req = 1'b1;
        for (int i = 0; i < 3000 && !got; i++) begin
            @(negedge clk);
            if (cpu_ack) begin got = 1; rd = cpu_rdata; end
        end
        cpu_req = 1'b0;
        chk(got, "R9 access terminated", got, 1);
        repeat (60) @(negedge clk);
        nexp = (sz == 2'b00) ? 2 : 1;
        chk(nrec - base_r == nexp, "R4 host cycles per access", nrec - base_r, nexp);
        chk(nack - base_a == 1, "R9 one ack per access", nack - base_a, 1);
        if (nrec - base_r == nexp) begin
            for (int i = 0; i < nexp; i++) begin
                logic [AW-2:0] ea;
                logic eu, el;
                logic [15:0] ed;
                int k;
                k  = base_r + i;
                ea = (sz == 2'b00) ? {a[AW-1:2], i[0]} : a[AW-1:1];
                eu = (sz == 2'b01) ? !a[0] : 1'b1;
                el = (sz == 2'b01) ?  a[0] : 1'b1;
                ed = (sz == 2'b00) ? ((i == 0) ? wd[31:16] : wd[15:0]) :
                     (sz == 2'b10) ? wd[15:0] : {wd[7:0], wd[7:0]};
                chk(rec_addr[k] == ea, "R4 host word address", 32'(rec_addr[k]), 32'(ea));
                chk(rec_up[k] == eu && rec_lo[k] == el, "R5 data strobe lanes",
                    {rec_up[k], rec_lo[k]}, {eu, el});
                chk(rec_rw[k] == !we, "R3 read/write level", rec_rw[k], !we);
                if (we) chk(rec_dout[k] == ed, "R6 host write data", rec_dout[k], ed);
            end
        end
        if (!we) begin
            if (sz == 2'b00)
                rexp = {rdfun({a[AW-1:2], 1'b0}), rdfun({a[AW-1:2], 1'b1})};
            else if (sz == 2'b10)
                rexp = {16'h0, rdfun(a[AW-1:1])};
            else begin
                logic [15:0] t;
                t = rdfun(a[AW-1:1]);
                rexp = {24'h0, a[0] ? t[7:0] : t[15:8]};
            end
            chk(rd == rexp, (sz == 2'b00) ? "R4 long read assembly" : "R6 read formatting",
                rd, rexp);
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        int cnt;
        int t;
        cpu_req = 0; cpu_we = 0; cpu_size = 2'b10; cpu_addr = '0; cpu_wdata = '0;
        host_bg_n = 1'b1; host_dtack_n = 1'b1; host_din = 16'h0;
        repeat (5) @(negedge clk);
        chk(host_br_n == 1'b1, "R1 no request during reset", host_br_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_br_n == 1'b0, "R1 request after reset", host_br_n, 0);
        chk(cpu_rst_n == 1'b0, "R1 processor held in reset", cpu_rst_n, 0);
        chk(host_own == 1'b0, "R1 bus not owned", host_own, 0);
        chk(cpu_ack == 1'b0, "R1 no ack", cpu_ack, 0);
        chk({host_as_n, host_uds_n, host_lds_n} == 3'b111, "R1 strobes idle",
            {host_as_n, host_uds_n, host_lds_n}, 3'b111);
        repeat (50) @(negedge clk);
        chk(cpu_rst_n == 1'b0 && host_own == 1'b0, "R2 waits for grant",
            {cpu_rst_n, host_own}, 0);
        chk(nrec == 0 && host_as_n, "R2 no host cycle before grant", nrec, 0);
        host_bg_n = 1'b0;
        cnt = 0;
        for (int i = 0; i < 10 && !cpu_rst_n; i++) begin @(negedge clk); cnt++; end
        chk(cnt == 3, "R2 reset release latency", cnt, 3);
        chk(host_own == 1'b1, "R2 bus owned after grant", host_own, 1);

        t = 0;
        for (int s = 0; s < 3; s++) begin
            for (int w = 0; w < 2; w++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    for (int ws = 0; ws < 4; ws++) begin
                        logic [1:0] sz;
                        sz = (s == 0) ? 2'b01 : (s == 1) ? 2'b10 : 2'b00;
                        do_access(24'h012340 + 24'(t * 16) + 24'(lo), w[0], sz,
                                  32'h8C4F_1B00 + 32'(t) * 32'h0103_0507, ws);
                        t++;
                    end
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule